// File: doc/BRIEF.md
# Pipelined Unidirectional Bus Scheduler

This block is a clock-accurate model of a row of `N` nodes that share one bus carrying data in a single direction, from lower to higher node index. A single strobe starts a bus cycle. At that moment every node that asserts its write enable places one `W`-bit message on the bus, all in the same slot and with no arbitration. Each message then moves one node position downstream on each clock. A message from node j therefore passes node i after i - j time units.

Each node has a programmable wait count. It gives the time unit within the bus cycle at which that node captures whatever is passing its tap. Programming the wait counts selects which sender each receiver hears. One bus cycle can therefore deliver a whole mapping from senders to downstream receivers. A uniform wait of k gives the shift j to j + k. Transfers toward lower indices cannot be expressed on this bus.

A bus cycle lasts `N` time units. The block reports the end of the cycle with a one-clock pulse. Wait counts can be written only while no bus cycle is running.

Top module: `pipe_bus_sched`

## Requirements
- R1: After reset, `rx_valid`, `busy` and `cycle_done` are 0, and every node's wait count is 0.
- R2: A `start` pulse while idle latches the time-0 bus contents. `busy` is then high for exactly `N` clocks after that edge. `cycle_done` is high for the single clock after the last time unit.
- R3: Suppose receiver i holds wait k, with 1 <= k <= i, and node i-k wrote in this cycle. Then `rx_valid[i]` is high for exactly one clock, in the (k+1)-th clock after the start edge. During that clock, slice i of `rx_data` (bits i*W and up) equals the data node i-k wrote.
- R4: When every receiver holds the same wait k and every node writes, each node i >= k receives node i-k's data. Nodes i < k receive nothing.
- R5: A node whose write enable is low at the start edge delivers nothing. A receiver timed to its slot sees no valid.
- R6: A wait count of 0 never produces a capture.
- R7: A wait count greater than the receiver's own index, including values of `N` or more, never produces a capture.
- R8: Wait loads presented while `busy` is high are ignored. The next bus cycle behaves according to the earlier values.
- R9: Different receivers may hold different wait counts. Each is served independently within the same bus cycle, and two receivers may capture the same sender.
- R10: A `start` pulse while `busy` is high neither restarts nor extends the running cycle, and it does not change the messages on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Bus cycle start strobe |
| wr_en | input | N | Per-node inject enable, sampled at the start edge |
| wr_data | input | N*W | Per-node message; node i in bits i*W and up |
| ld_en | input | N | Per-node wait count load enable |
| ld_wait | input | N*CW | Per-node wait count value; node i in bits i*CW and up |
| rx_data | output | N*W | Per-node captured message |
| rx_valid | output | N | Per-node one-clock capture flag |
| busy | output | 1 | High while a bus cycle is running |
| cycle_done | output | 1 | One-clock pulse after the last time unit |

## Verification
The hardest condition to reach from the ports is an attempt to reprogram the wait counts, or to restart the bus, while a cycle is already moving messages. The ignored load can only be observed in the following cycle. The bench therefore drives a second `start` and a full set of different wait loads in the middle of a running cycle. It checks that the current cycle's deliveries and end timing do not change. It then runs a fresh cycle whose deliveries must still match the old wait counts. Out-of-range waits are placed on the same receivers that also hold valid traffic in other runs, so any missing masking shows up as a spurious valid flag.

// File: rtl/pipe_bus_sched.sv
module pipe_bus_sched #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int CW = $clog2(N) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N-1:0]    wr_en,
  input  logic [N*W-1:0]  wr_data,
  input  logic [N-1:0]    ld_en,
  input  logic [N*CW-1:0] ld_wait,
  output logic [N*W-1:0]  rx_data,
  output logic [N-1:0]    rx_valid,
  output logic            busy,
  output logic            cycle_done
);

  logic [W-1:0]  slot_d [N];
  logic [N-1:0]  slot_v;
  logic [CW-1:0] wait_q [N];
  logic [CW-1:0] t_q;
  logic [N-1:0]  hit;
  logic          busy_q, done_q;

  wire last = busy_q && (t_q == CW'(N-1));
  wire go   = !busy_q && start;

  assign busy       = busy_q;
  assign cycle_done = done_q;

  always_comb
    for (int i = 0; i < N; i++)
      hit[i] = busy_q && (t_q != '0) && (t_q == wait_q[i]) && slot_v[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      t_q    <= '0;
    end else begin
      done_q <= last;
      if (go) begin
        busy_q <= 1'b1;
        t_q    <= '0;
      end else if (busy_q) begin
        t_q <= t_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v <= '0;
      for (int i = 0; i < N; i++) slot_d[i] <= '0;
    end else if (go) begin
      slot_v <= wr_en;
      for (int i = 0; i < N; i++) slot_d[i] <= wr_data[i*W +: W];
    end else if (busy_q) begin
      slot_v <= {slot_v[N-2:0], 1'b0};
      slot_d[0] <= '0;
      for (int i = 1; i < N; i++) slot_d[i] <= slot_d[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= '0;
      rx_data  <= '0;
      for (int i = 0; i < N; i++) wait_q[i] <= '0;
    end else begin
      rx_valid <= hit;
      for (int i = 0; i < N; i++) begin
        if (hit[i]) rx_data[i*W +: W] <= slot_d[i];
        if (!busy_q && ld_en[i]) wait_q[i] <= ld_wait[i*CW +: CW];
      end
    end
  end

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  // R3
  valid_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid != '0) |-> $past(busy_q));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last) |=> (busy_q && t_q == $past(t_q) + 1'b1));

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R6
    wait_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[g] |-> (wait_q[g] != '0));
    // R7
    wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[g] |-> (wait_q[g] <= CW'(g)));
    // R8
    load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && ld_en[g]) |=> $stable(wait_q[g]));
  end

endmodule

// File: tb/tb_pipe_bus_sched.sv
module tb_pipe_bus_sched;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int CW = $clog2(N) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [N-1:0]    wr_en = '0;
  logic [N*W-1:0]  wr_data = '0;
  logic [N-1:0]    ld_en = '0;
  logic [N*CW-1:0] ld_wait = '0;
  logic [N*W-1:0]  rx_data;
  logic [N-1:0]    rx_valid;
  logic            busy, cycle_done;

  int checks = 0, failures = 0;
  bit finished = 0;
  int mw [N];

  always #2 clk = ~clk;

  pipe_bus_sched #(.N(N), .W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_data(wr_data),
    .ld_en(ld_en), .ld_wait(ld_wait), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .cycle_done(cycle_done));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int w [N]);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      ld_wait[i*CW +: CW] = CW'(w[i]);
      mw[i] = w[i];
    end
    ld_en = '1;
    @(negedge clk);
    ld_en = '0;
  endtask

  // One bus cycle, checked against the model; mid=1 adds a start and loads mid-cycle.
  task automatic run(input logic [N-1:0] we, input int seed, input bit mid, input string tag);
    logic [W-1:0] d [N];
    logic [N-1:0] ev;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      d[i] = W'(seed + 17 * i + 3);
      wr_data[i*W +: W] = d[i];
    end
    wr_en = we;
    start = 1'b1;
    for (int c = 0; c <= N + 1; c++) begin
      @(negedge clk);
      start = 1'b0;
      wr_en = '0;
      ld_en = '0;
      if (mid && c == 1) begin
        start = 1'b1;
        wr_en = '1;
        ld_en = '1;
        for (int i = 0; i < N; i++) ld_wait[i*CW +: CW] = CW'(1);
        for (int i = 0; i < N; i++) wr_data[i*W +: W] = 8'hEE;
      end
      ev = '0;
      for (int i = 0; i < N; i++)
        if (mw[i] >= 1 && mw[i] <= i && we[i - mw[i]] && c == mw[i] + 1) ev[i] = 1'b1;
      // R2 R10
      chk(busy == (c < N), {tag, " R2 R10 busy"}, busy, c < N);
      chk(cycle_done == (c == N), {tag, " R2 cycle_done"}, cycle_done, c == N);
      // R3 R4 R5 R6 R7 R8 R9
      chk(rx_valid == ev, {tag, " R3 rx_valid"}, rx_valid, ev);
      for (int i = 0; i < N; i++)
        if (ev[i])
          chk(rx_data[i*W +: W] == d[i - mw[i]], {tag, " R3 rx_data"},
              rx_data[i*W +: W], d[i - mw[i]]);
    end
  endtask

  task automatic t_reset;
    int z [N];
    for (int i = 0; i < N; i++) begin z[i] = 0; mw[i] = 0; end
    chk(rx_valid == '0, "R1 rx_valid", rx_valid, 0);
    chk(!busy && !cycle_done, "R1 busy/done", {busy, cycle_done}, 0);
    run('1, 8'h10, 0, "R1 R6 zero waits");
  endtask

  task automatic t_shift(input int k);
    int w [N];
    for (int i = 0; i < N; i++) w[i] = k;
    load(w);
    run('1, 8'h20 + k, 0, "R4 shift");
  endtask

  task automatic t_sparse;
    int w [N];
    for (int i = 0; i < N; i++) w[i] = 2;
    load(w);
    run(8'b0101_0010, 8'h40, 0, "R5 sparse");
  endtask

  task automatic t_mixed;
    int w [N] = '{0, 1, 2, 1, 4, 6, 0, 15};
    load(w);
    run('1, 8'h60, 0, "R6 R7 R9 mixed");
    w = '{3, 5, 1, 3, 3, 5, 6, 7};
    load(w);
    run('1, 8'h70, 0, "R7 R9 mixed2");
  endtask

  task automatic t_midcycle;
    int w [N] = '{0, 0, 2, 3, 2, 5, 3, 7};
    load(w);
    run(8'b1011_0111, 8'h80, 1, "R8 R10 midcycle");
    run('1, 8'h90, 0, "R8 after");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shift(1);
    t_shift(3);
    t_shift(N - 1);
    t_sparse();
    t_mixed();
    t_midcycle();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule